// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block turns one host request into the ordered train of bus write cycles that a parallel NOR flash expects before it will identify itself, program a word, erase or answer a query. The host presents an operation code, a word address and a data word, and pulses a start strobe. The sequencer raises busy and hands the write cycles one at a time to an external bus timing engine. It moves to the next cycle only when that engine acknowledges the current one. When the final cycle is acknowledged, busy drops and done pulses.

Each operation has its own fixed length, from one write to six. Command cycles target fixed word addresses on a 16-bit device. Word addresses become byte addresses by a left shift of one, and the bank base parameter is added on top. The block does not handle pin timing, read data capture, completion polling or buffered programming.

Top module: `nor_cmd_seq`

## Requirements
- R1: Identify-entry, program, sector erase and chip erase each open with two unlock writes: data 0xAA to word 0x555, then data 0x55 to word 0x2AA.
- R2: Operation code 0 (identify entry) issues three writes, the third being 0x90 to word 0x555.
- R3: Operation code 2 (program) issues four writes: unlock pair, 0xA0 to word 0x555, then req_data to the word req_addr.
- R4: Operation code 3 (sector erase) issues six writes: unlock pair, 0x80 to 0x555, 0xAA to 0x555, 0x55 to 0x2AA, then 0x30 to the word req_addr.
- R5: Operation code 4 (chip erase) issues six writes whose first five match sector erase and whose last is 0x10 to word 0x555.
- R6: Operation code 5 (query entry) issues one write of 0x98 to word 0x55.
- R7: Operation code 1 (return to read) issues one write of 0xF0 to word 0, the bank base.
- R8: mem_addr equals BANK_BASE plus twice the word address, truncated to ADDR_W bits; command bytes are zero-extended onto mem_data.
- R9: mem_wr, mem_addr and mem_data hold steady until mem_ack is sampled high; the next write appears on the clock edge that samples the acknowledge.
- R10: On the edge that samples the acknowledge of the last write, busy and mem_wr fall and done goes high for exactly one cycle.
- R11: A start strobe while busy is ignored; the running sequence finishes unchanged.
- R12: A start with code 6 or 7 leaves the block idle (no write, busy low) and pulses err for one cycle.
- R13: After reset, busy, done, err and mem_wr are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_op | input | 3 | Operation code |
| req_addr | input | ADDR_W-1 | Target word address (program, sector erase) |
| req_data | input | DATA_W | Word to program |
| req_start | input | 1 | Start strobe, sampled when idle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse after the last acknowledge |
| err | output | 1 | One-cycle pulse for an unknown code |
| mem_addr | output | ADDR_W | Byte address of the current write |
| mem_data | output | DATA_W | Data of the current write |
| mem_wr | output | 1 | Write request level, held until acknowledged |
| mem_ack | input | 1 | Write acknowledge from the bus timing engine |

## Verification
The bench runs every operation over the lowest, highest and a mixed word address and data, with acknowledge delays of zero, one and two cycles. A sequencer that stepped without an acknowledge, or let address or data drift during a stall, would show a wrong or doubled write. One that got a sequence length wrong would show an extra write or a missing done. Carry in the base addition and truncation at the top word address are compared to arithmetic in the bench. Start pulses injected mid-sequence and unknown codes check that a design accepting them would corrupt the train or start a write.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [2:0] {
    OP_IDENT = 3'd0,
    OP_RDRST = 3'd1,
    OP_PROG  = 3'd2,
    OP_SECT  = 3'd3,
    OP_CHIP  = 3'd4,
    OP_QUERY = 3'd5
  } nor_op_e;

  localparam int STEP_W = 3;

  function automatic logic op_known(input logic [2:0] op);
    return (op <= 3'd5);
  endfunction

  function automatic logic [STEP_W-1:0] op_last(input logic [2:0] op);
    case (op)
      3'd0:    return 3'd2;
      3'd2:    return 3'd3;
      3'd3:    return 3'd5;
      3'd4:    return 3'd5;
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/nor_seq_steps.sv
module nor_seq_steps
  import nor_seq_pkg::*;
#(
  parameter int WAW    = 23,
  parameter int DATA_W = 16
) (
  input  logic [2:0]        op,
  input  logic [STEP_W-1:0] step,
  input  logic [WAW-1:0]    uaddr,
  input  logic [DATA_W-1:0] udata,
  output logic [WAW-1:0]    word_addr,
  output logic [DATA_W-1:0] wdata,
  output logic              is_last
);

  localparam logic [WAW-1:0] W_KEY1  = WAW'(12'h555);
  localparam logic [WAW-1:0] W_KEY2  = WAW'(12'h2AA);
  localparam logic [WAW-1:0] W_QUERY = WAW'(12'h055);
  localparam logic [WAW-1:0] W_ZERO  = '0;

  localparam logic [7:0] B_KEY1  = 8'hAA;
  localparam logic [7:0] B_KEY2  = 8'h55;
  localparam logic [7:0] B_IDENT = 8'h90;
  localparam logic [7:0] B_PROG  = 8'hA0;
  localparam logic [7:0] B_ARM   = 8'h80;
  localparam logic [7:0] B_SECT  = 8'h30;
  localparam logic [7:0] B_CHIP  = 8'h10;
  localparam logic [7:0] B_QUERY = 8'h98;
  localparam logic [7:0] B_RDRST = 8'hF0;

  logic [7:0] cmd_byte;
  logic       use_user_data;

  always_comb begin
    word_addr     = W_ZERO;
    cmd_byte      = 8'h00;
    use_user_data = 1'b0;
    case (op)
      OP_RDRST: begin
        word_addr = W_ZERO;
        cmd_byte  = B_RDRST;
      end
      OP_QUERY: begin
        word_addr = W_QUERY;
        cmd_byte  = B_QUERY;
      end
      OP_IDENT, OP_PROG, OP_SECT, OP_CHIP: begin
        case (step)
          3'd0: begin word_addr = W_KEY1; cmd_byte = B_KEY1; end
          3'd1: begin word_addr = W_KEY2; cmd_byte = B_KEY2; end
          3'd2: begin
            word_addr = W_KEY1;
            if (op == OP_IDENT)     cmd_byte = B_IDENT;
            else if (op == OP_PROG) cmd_byte = B_PROG;
            else                    cmd_byte = B_ARM;
          end
          3'd3: begin
            if (op == OP_PROG) begin
              word_addr     = uaddr;
              use_user_data = 1'b1;
            end else begin
              word_addr = W_KEY1;
              cmd_byte  = B_KEY1;
            end
          end
          3'd4: begin word_addr = W_KEY2; cmd_byte = B_KEY2; end
          3'd5: begin
            if (op == OP_SECT) begin
              word_addr = uaddr;
              cmd_byte  = B_SECT;
            end else begin
              word_addr = W_KEY1;
              cmd_byte  = B_CHIP;
            end
          end
          default: begin
            word_addr = W_ZERO;
            cmd_byte  = 8'h00;
          end
        endcase
      end
      default: begin
        word_addr = W_ZERO;
        cmd_byte  = 8'h00;
      end
    endcase
  end

  assign wdata   = use_user_data ? udata : DATA_W'(cmd_byte);
  assign is_last = (step == op_last(op));

endmodule

// File: rtl/nor_seq_addr.sv
module nor_seq_addr #(
  parameter int                ADDR_W    = 24,
  parameter logic [ADDR_W-1:0] BANK_BASE = '0
) (
  input  logic [ADDR_W-2:0] word_addr,
  output logic [ADDR_W-1:0] byte_addr
);

  logic [ADDR_W-1:0] shifted;

  assign shifted   = {word_addr, 1'b0};
  assign byte_addr = BANK_BASE + shifted;

endmodule

// File: rtl/nor_seq_ctrl.sv
module nor_seq_ctrl
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-2:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              req_start,
  input  logic              mem_ack,
  input  logic [ADDR_W-1:0] nxt_addr,
  input  logic [DATA_W-1:0] nxt_data,
  input  logic              nxt_last,
  output logic [2:0]        sel_op,
  output logic [STEP_W-1:0] sel_step,
  output logic [ADDR_W-2:0] sel_uaddr,
  output logic [DATA_W-1:0] sel_udata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              mem_wr
);

  logic              busy_q, done_q, err_q, wr_q, last_q;
  logic [2:0]        op_q;
  logic [STEP_W-1:0] step_q;
  logic [ADDR_W-2:0] uaddr_q;
  logic [DATA_W-1:0] udata_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              accept, reject, advance;

  assign accept  = req_start && !busy_q && op_known(req_op);
  assign reject  = req_start && !busy_q && !op_known(req_op);
  assign advance = busy_q && mem_ack;

  always_comb begin
    if (busy_q) begin
      sel_op    = op_q;
      sel_step  = step_q + 1'b1;
      sel_uaddr = uaddr_q;
      sel_udata = udata_q;
    end else begin
      sel_op    = req_op;
      sel_step  = '0;
      sel_uaddr = req_addr;
      sel_udata = req_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      wr_q    <= 1'b0;
      last_q  <= 1'b0;
      op_q    <= '0;
      step_q  <= '0;
      uaddr_q <= '0;
      udata_q <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= reject;
      if (accept) begin
        busy_q  <= 1'b1;
        wr_q    <= 1'b1;
        op_q    <= req_op;
        uaddr_q <= req_addr;
        udata_q <= req_data;
        step_q  <= '0;
        addr_q  <= nxt_addr;
        data_q  <= nxt_data;
        last_q  <= nxt_last;
      end else if (advance) begin
        if (last_q) begin
          busy_q <= 1'b0;
          wr_q   <= 1'b0;
          done_q <= 1'b1;
        end else begin
          step_q <= step_q + 1'b1;
          addr_q <= nxt_addr;
          data_q <= nxt_data;
          last_q <= nxt_last;
        end
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign err      = err_q;
  assign mem_addr = addr_q;
  assign mem_data = data_q;
  assign mem_wr   = wr_q;

  // R9: a stalled write keeps its strobe, address and data
  p_hold_stall_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_q && !mem_ack) |=> (wr_q && $stable(addr_q) && $stable(data_q)));

  // R10: done lasts one cycle and follows an acknowledged write
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  p_done_after_ack_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> (!busy_q && !wr_q && $past(wr_q && mem_ack)));

  // R11: a running sequence does not change operation on a new start
  p_refuse_busy_r11: assert property (@(posedge clk) disable iff (rst)
    (busy_q && req_start && !mem_ack) |=> ($stable(op_q) && $stable(step_q)));

  // R12: an unknown code never starts a write
  p_err_idle_r12: assert property (@(posedge clk) disable iff (rst)
    err_q |-> (!busy_q && !wr_q));

  // R2: the step index never passes the last step of the operation
  p_step_range_r2: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (step_q <= op_last(op_q)));

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int                ADDR_W    = 24,
  parameter int                DATA_W    = 16,
  parameter logic [ADDR_W-1:0] BANK_BASE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-2:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              req_start,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              mem_wr,
  input  logic              mem_ack
);

  localparam int WAW = ADDR_W - 1;

  logic [2:0]        sel_op;
  logic [STEP_W-1:0] sel_step;
  logic [WAW-1:0]    sel_uaddr;
  logic [DATA_W-1:0] sel_udata;
  logic [WAW-1:0]    step_word;
  logic [DATA_W-1:0] step_data;
  logic              step_last;
  logic [ADDR_W-1:0] step_byte;

  nor_seq_steps #(.WAW(WAW), .DATA_W(DATA_W)) u_steps (
    .op        (sel_op),
    .step      (sel_step),
    .uaddr     (sel_uaddr),
    .udata     (sel_udata),
    .word_addr (step_word),
    .wdata     (step_data),
    .is_last   (step_last)
  );

  nor_seq_addr #(.ADDR_W(ADDR_W), .BANK_BASE(BANK_BASE)) u_addr (
    .word_addr (step_word),
    .byte_addr (step_byte)
  );

  nor_seq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .req_data  (req_data),
    .req_start (req_start),
    .mem_ack   (mem_ack),
    .nxt_addr  (step_byte),
    .nxt_data  (step_data),
    .nxt_last  (step_last),
    .sel_op    (sel_op),
    .sel_step  (sel_step),
    .sel_uaddr (sel_uaddr),
    .sel_udata (sel_udata),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .mem_wr    (mem_wr)
  );

  // R13: nothing is pending in the cycle after reset
  p_reset_quiet_r13: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !done && !err && !mem_wr));

endmodule

// File: tb/nor_cmd_seq_bench.sv
module nor_cmd_seq_bench;

  localparam int            CLK_PERIOD = 10;
  localparam int            AW         = 20;
  localparam int            DW         = 16;
  localparam logic [AW-1:0] BASE       = 20'h40000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    req_op = '0;
  logic [AW-2:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          req_start = 1'b0;
  logic          busy, done, err, mem_wr;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;
  logic          mem_ack = 1'b0;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_cmd_seq #(.ADDR_W(AW), .DATA_W(DW), .BANK_BASE(BASE)) u_nor_cmd_seq (
    .clk(clk), .rst(rst), .req_op(req_op), .req_addr(req_addr),
    .req_data(req_data), .req_start(req_start), .busy(busy), .done(done),
    .err(err), .mem_addr(mem_addr), .mem_data(mem_data), .mem_wr(mem_wr),
    .mem_ack(mem_ack)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int seq_len(input int op);
    int lens[6] = '{3, 1, 4, 6, 6, 1};
    return lens[op];
  endfunction

  function automatic int exp_word(input int op, input int i, input int ua);
    int ers[6] = '{'h555, 'h2AA, 'h555, 'h555, 'h2AA, 0};
    case (op)
      1: return 0;
      5: return 'h55;
      2: return (i == 3) ? ua : ers[i];
      3: return (i == 5) ? ua : ers[i];
      4: return (i == 5) ? 'h555 : ers[i];
      default: return ers[i];
    endcase
  endfunction

  function automatic int exp_data(input int op, input int i, input int ud);
    int ers[6] = '{'hAA, 'h55, 'h80, 'hAA, 'h55, 'h30};
    case (op)
      0: return (i == 2) ? 'h90 : ers[i];
      1: return 'hF0;
      5: return 'h98;
      2: return (i == 3) ? ud : ((i == 2) ? 'hA0 : ers[i]);
      4: return (i == 5) ? 'h10 : ers[i];
      default: return ers[i];
    endcase
  endfunction

  function automatic string op_tag(input int op, input int i);
    if (i < 2 && op != 1 && op != 5) return "R1";
    case (op)
      0: return "R2";
      1: return "R7";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic run_op(input int op, input int ua, input int ud, input int dly, input bit poke);
    longint eaddr;
    @(negedge clk);
    req_op = 3'(op); req_addr = (AW-1)'(ua); req_data = DW'(ud); req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    check(busy == 1'b1, "R10 busy after start", busy, 1);
    for (int i = 0; i < seq_len(op); i++) begin
      eaddr = (longint'(BASE) + 2 * longint'(exp_word(op, i, ua))) % (longint'(1) << AW);
      check(mem_wr == 1'b1, "R9 strobe", mem_wr, 1);
      check(mem_addr == AW'(eaddr), (i == 3 && op == 2) ? "R8 user address" : op_tag(op, i), mem_addr, eaddr);
      check(mem_data == DW'(exp_data(op, i, ud)), op_tag(op, i), mem_data, exp_data(op, i, ud));
      for (int d = 0; d < dly; d++) begin
        if (poke && d == 0) begin req_op = 3'd5; req_start = 1'b1; end
        @(negedge clk);
        req_start = 1'b0;
        check(mem_wr && mem_addr == AW'(eaddr) && mem_data == DW'(exp_data(op, i, ud)),
              poke ? "R11 start while busy" : "R9 hold during stall", mem_addr, eaddr);
      end
      if (poke && dly == 0 && i == 0) begin req_op = 3'd1; req_start = 1'b1; end
      mem_ack = 1'b1;
      @(negedge clk);
      mem_ack = 1'b0; req_start = 1'b0;
    end
    check(done == 1'b1, "R10 done", done, 1);
    check(busy == 1'b0 && mem_wr == 1'b0, "R10 idle at done", {busy, mem_wr}, 0);
    @(negedge clk);
    check(done == 1'b0, "R10 done one cycle", done, 0);
    check(mem_wr == 1'b0, "R11 no extra write", mem_wr, 0);
  endtask

  initial begin
    int uas[3] = '{0, (1 << (AW-1)) - 1, 'h2B4C6};
    int uds[3] = '{0, 'hFFFF, 'hA5C3};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !err && !mem_wr, "R13 reset state", {busy, done, err, mem_wr}, 0);
    for (int op = 0; op < 6; op++)
      for (int p = 0; p < 3; p++)
        run_op(op, uas[p], uds[p], (op + p) % 3, p == 2);
    for (int u = 6; u < 8; u++) begin
      @(negedge clk);
      req_op = 3'(u); req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
      check(err == 1'b1, "R12 err pulse", err, 1);
      check(!busy && !mem_wr, "R12 stays idle", {busy, mem_wr}, 0);
      @(negedge clk);
      check(err == 1'b0 && !mem_wr, "R12 err one cycle", err, 0);
    end
    run_op(2, 'h12345, 'h0F0F, 1, 1'b0);
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!ended) begin
      ended = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule